// File: doc/BRIEF.md
# PCI Interrupt Steering Register Unit

This block is the configuration space of the interrupt-steering function in a PCI-to-ISA bridge. Software reaches it through a configuration port made of a function number, a byte address, write data and a write strobe. The read data follows the addressed byte combinationally. Four routing bytes decide which ISA interrupt line, if any, each of the four PCI interrupt pins drives. Besides the routing bytes, the unit holds a small fixed header: identification, class, command and status.

The four interrupt pins enter active high in pin order: bit 0 is A, bit 1 B, bit 2 C, bit 3 D. Each pin whose route is enabled is ORed onto the selected bit of a 16-line IRQ vector. That vector is registered, so it follows its inputs with one clock of latency. The ISA interrupt controller, edge-to-level conversion and bus timing sit outside this unit.

Top module: `irqsteer_top`

## Requirements
- R1: With function 0, bytes 0x00..0x03 read 0x39, 0x10, 0x08, 0x00. Byte 0x0A reads 0x01 and byte 0x0B reads 0x06. Writes never change these bytes.
- R2: Byte 0x04 reads 0x07 after reset. A write stores (data AND 0x08) OR 0x07, so only bit 3 is writable and bits 2:0 always read 1.
- R3: Byte 0x05 always reads 0x00. Byte 0x06 reads 0x80 after reset and 0x00 after any write to it. Byte 0x07 always reads 0x02.
- R4: With a non-zero function number, every read returns 0xFF and writes change nothing.
- R5: The routing bytes are 0x41 for pin A, 0x42 for pin C, 0x43 for pin B and 0x44 for pin D. Each one reads back the full byte last written to it.
- R6: Writes to 0x0E, to 0x0F..0x40 and to any address that holds no register are discarded. Those addresses read 0x00.
- R7: When bit 7 of a routing byte is 0, its pin drives the IRQ line numbered by bits 3:0. Bits 6:4 are ignored.
- R8: When bit 7 of a routing byte is 1, its pin drives no IRQ line.
- R9: When several enabled pins select the same line, that line is the OR of those pins.
- R10: irqOut is registered. It reflects intIn and the routing bytes as they were at the previous rising clock edge.
- R11: Reset (rstN low) sets all four routing bytes to 0x80 and clears irqOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgFunc | input | 3 | Configuration function number |
| cfgAddr | input | 8 | Configuration byte address |
| cfgWr | input | 1 | Write strobe, taken at the rising edge |
| cfgWrData | input | 8 | Write data |
| cfgRdData | output | 8 | Read data for cfgFunc/cfgAddr (combinational) |
| intIn | input | 4 | PCI interrupt pins A..D, active high |
| irqOut | output | 16 | Registered ISA IRQ line vector |

## Verification
A full address sweep and writes of all-ones and all-zeros separate the fixed, masked, self-clearing and discarded bytes from each other. Walking one pin at a time with distinct targets shows whether the slot-to-pin order is swapped. It also shows whether the upper bits of a routing byte leak into the line select. Pointing two pins at one line tells OR merging apart from last-writer selection. A long random phase mixes pin toggles with route rewrites, and a cycle-accurate model then catches any latency off by one.

// File: rtl/irqsteer_pkg.sv
package irqsteer_pkg;
  localparam int INT_COUNT = 4;
  localparam int IRQ_COUNT = 16;
  localparam int SEL_W = $clog2(IRQ_COUNT);
  localparam int SLOT_W = $clog2(INT_COUNT);
  localparam int BYTE_W = 8;

  localparam logic [7:0] VID_LO = 8'h39;
  localparam logic [7:0] VID_HI = 8'h10;
  localparam logic [7:0] DID_LO = 8'h08;
  localparam logic [7:0] CLASS_SUB = 8'h01;
  localparam logic [7:0] CLASS_BASE = 8'h06;
  localparam logic [7:0] DEVSEL_BYTE = 8'h02;
  localparam logic [7:0] CMD_FIXED = 8'h07;
  localparam int CMD_KEEP_BIT = 3;
  localparam logic [7:0] STAT_RESET = 8'h80;
  localparam logic [7:0] ROUTE_BASE = 8'h41;
  localparam logic [7:0] ROUTE_RESET = 8'h80;
  localparam int ROUTE_OFF_BIT = 7;

  typedef enum logic [3:0] {
    RD_ZERO, RD_FF, RD_VID_LO, RD_VID_HI, RD_DID_LO, RD_CMD, RD_STAT,
    RD_DEVSEL, RD_CLASS_SUB, RD_CLASS_BASE, RD_ROUTE
  } rdSel_e;

  typedef struct packed {
    logic                 cmdWr;
    logic                 statWr;
    logic [INT_COUNT-1:0] routeWr;
    logic [BYTE_W-1:0]    wrData;
    rdSel_e               rdSel;
    logic [SLOT_W-1:0]    rdSlot;
  } strobe_t;

  // Register slot k steers this pin (slots 1 and 2 are crossed).
  function automatic logic [SLOT_W-1:0] slotToPin(input logic [SLOT_W-1:0] slot);
    case (slot)
      SLOT_W'(1): return SLOT_W'(2);
      SLOT_W'(2): return SLOT_W'(1);
      default:    return slot;
    endcase
  endfunction
endpackage

// File: rtl/irqsteer_ctrl.sv
module irqsteer_ctrl
  import irqsteer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          cfgFunc,
  input  logic [7:0]          cfgAddr,
  input  logic                cfgWr,
  input  logic [BYTE_W-1:0]   cfgWrData,
  output strobe_t             stb
);
  logic       funcOk;
  logic       wrOk;
  logic [7:0] routeOff;
  logic       routeHit;

  always_comb begin
    funcOk   = (cfgFunc == 3'd0);
    wrOk     = funcOk && cfgWr;
    routeOff = cfgAddr - ROUTE_BASE;
    routeHit = (cfgAddr >= ROUTE_BASE) && (routeOff < 8'(INT_COUNT));

    stb.cmdWr   = wrOk && (cfgAddr == 8'h04);
    stb.statWr  = wrOk && (cfgAddr == 8'h06);
    stb.routeWr = (wrOk && routeHit) ? (INT_COUNT'(1) << routeOff[SLOT_W-1:0])
                                     : '0;
    stb.wrData  = cfgWrData;
    stb.rdSlot  = routeOff[SLOT_W-1:0];

    if (!funcOk) stb.rdSel = RD_FF;
    else begin
      case (cfgAddr)
        8'h00:   stb.rdSel = RD_VID_LO;
        8'h01:   stb.rdSel = RD_VID_HI;
        8'h02:   stb.rdSel = RD_DID_LO;
        8'h04:   stb.rdSel = RD_CMD;
        8'h06:   stb.rdSel = RD_STAT;
        8'h07:   stb.rdSel = RD_DEVSEL;
        8'h0A:   stb.rdSel = RD_CLASS_SUB;
        8'h0B:   stb.rdSel = RD_CLASS_BASE;
        default: stb.rdSel = routeHit ? RD_ROUTE : RD_ZERO;
      endcase
    end
  end

  // R5: at most one register is written per cycle
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cmdWr, stb.statWr, stb.routeWr}));

  // R4: a foreign function produces no write strobe
  a_r4_foreign_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == RD_FF) |-> (stb.routeWr == '0 && !stb.cmdWr && !stb.statWr));
endmodule

// File: rtl/irqsteer_datapath.sv
module irqsteer_datapath
  import irqsteer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [INT_COUNT-1:0] intIn,
  output logic [BYTE_W-1:0]    rdData,
  output logic [IRQ_COUNT-1:0] irqOut
);
  logic                 cmdKeep;
  logic                 statFlag;
  logic [BYTE_W-1:0]    routeReg [INT_COUNT];
  logic [IRQ_COUNT-1:0] nextIrq;
  logic                 allOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdKeep  <= 1'b0;
      statFlag <= 1'b1;
    end else begin
      if (stb.cmdWr)  cmdKeep  <= stb.wrData[CMD_KEEP_BIT];
      if (stb.statWr) statFlag <= 1'b0;
    end
  end

  for (genvar s = 0; s < INT_COUNT; s++) begin : g_route
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                routeReg[s] <= ROUTE_RESET;
      else if (stb.routeWr[s])  routeReg[s] <= stb.wrData;
    end
  end

  always_comb begin
    nextIrq = '0;
    allOff  = 1'b1;
    for (int s = 0; s < INT_COUNT; s++) begin
      if (!routeReg[s][ROUTE_OFF_BIT]) begin
        allOff = 1'b0;
        if (intIn[slotToPin(SLOT_W'(s))])
          nextIrq[routeReg[s][SEL_W-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= nextIrq;
  end

  always_comb begin
    case (stb.rdSel)
      RD_FF:         rdData = 8'hFF;
      RD_VID_LO:     rdData = VID_LO;
      RD_VID_HI:     rdData = VID_HI;
      RD_DID_LO:     rdData = DID_LO;
      RD_CMD:        rdData = CMD_FIXED | (8'(cmdKeep) << CMD_KEEP_BIT);
      RD_STAT:       rdData = statFlag ? STAT_RESET : 8'h00;
      RD_DEVSEL:     rdData = DEVSEL_BYTE;
      RD_CLASS_SUB:  rdData = CLASS_SUB;
      RD_CLASS_BASE: rdData = CLASS_BASE;
      RD_ROUTE:      rdData = routeReg[stb.rdSlot];
      default:       rdData = 8'h00;
    endcase
  end

  // R2: command byte keeps its fixed low bits and no high bits
  a_r2_cmd_shape: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == RD_CMD) |-> (rdData[2:0] == 3'b111 && rdData[7:4] == 4'h0));

  // R3: status flag, once cleared, stays cleared
  a_r3_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !statFlag |=> !statFlag);

  // R10: no IRQ line rises without a pin having been high one edge before
  a_r10_irq_needs_pin: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> ($past(intIn) != '0));

  // R8: with every route disabled, the next vector is empty
  a_r8_all_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    allOff |=> (irqOut == '0));
endmodule

// File: rtl/irqsteer_top.sv
module irqsteer_top
  import irqsteer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cfgFunc,
  input  logic [7:0]           cfgAddr,
  input  logic                 cfgWr,
  input  logic [BYTE_W-1:0]    cfgWrData,
  output logic [BYTE_W-1:0]    cfgRdData,
  input  logic [INT_COUNT-1:0] intIn,
  output logic [IRQ_COUNT-1:0] irqOut
);
  strobe_t stb;

  irqsteer_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgFunc(cfgFunc), .cfgAddr(cfgAddr),
    .cfgWr(cfgWr), .cfgWrData(cfgWrData), .stb(stb)
  );

  irqsteer_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .intIn(intIn),
    .rdData(cfgRdData), .irqOut(irqOut)
  );

  // R4: foreign function reads as all ones
  a_r4_func_reads_ff: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFunc != 3'd0) |-> (cfgRdData == 8'hFF));
endmodule

// File: tb/test_irqsteer_top.sv
module test_irqsteer_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgFunc = '0;
  logic [7:0]  cfgAddr = '0;
  logic        cfgWr = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic [3:0]  intIn = '0;
  logic [15:0] irqOut;

  int    errCnt = 0;
  int    chkCnt = 0;
  bit    done = 1'b0;
  string irqTag = "R11";

  // model state, indexed by register slot 0..3 (addresses 0x41..0x44)
  logic [7:0]  mRoute [4];
  bit          mCmd;
  bit          mStat;
  logic [15:0] mIrq;
  int          pinOfSlot [4] = '{0, 2, 1, 3};

  always #(CLK_PERIOD/2) clk = ~clk;

  irqsteer_top i_irqsteer_top (
    .clk(clk), .rstN(rstN), .cfgFunc(cfgFunc), .cfgAddr(cfgAddr),
    .cfgWr(cfgWr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .intIn(intIn), .irqOut(irqOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < 4; s++) mRoute[s] = 8'h80;
      mCmd = 0; mStat = 1; mIrq = '0;
    end else begin
      logic [15:0] nx;
      nx = '0;
      for (int s = 0; s < 4; s++)
        if (!mRoute[s][7] && intIn[pinOfSlot[s]]) nx[mRoute[s][3:0]] = 1'b1;
      if (cfgWr && cfgFunc == 0) begin
        if (cfgAddr == 8'h04) mCmd = cfgWrData[3];
        if (cfgAddr == 8'h06) mStat = 0;
        if (cfgAddr >= 8'h41 && cfgAddr <= 8'h44) mRoute[cfgAddr - 8'h41] = cfgWrData;
      end
      mIrq = nx;
    end
  end

  function automatic logic [7:0] expRead(input logic [2:0] f, input logic [7:0] a);
    if (f != 0) return 8'hFF;
    case (a)
      8'h00: return 8'h39;
      8'h01: return 8'h10;
      8'h02: return 8'h08;
      8'h04: return mCmd ? 8'h0F : 8'h07;
      8'h06: return mStat ? 8'h80 : 8'h00;
      8'h07: return 8'h02;
      8'h0A: return 8'h01;
      8'h0B: return 8'h06;
      8'h41, 8'h42, 8'h43, 8'h44: return mRoute[a - 8'h41];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] f, input logic [7:0] a);
    if (f != 0) return "R4";
    if (a <= 8'h03 || a == 8'h0A || a == 8'h0B) return "R1";
    if (a == 8'h04) return "R2";
    if (a >= 8'h05 && a <= 8'h07) return "R3";
    if (a >= 8'h41 && a <= 8'h44) return "R5";
    return "R6";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(irqOut === mIrq, irqTag, irqOut, mIrq);
      if (rstN) begin
        logic [7:0] e;
        e = expRead(cfgFunc, cfgAddr);
        check(cfgRdData === e, tagFor(cfgFunc, cfgAddr), cfgRdData, e);
      end
    end
  end

  task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cfgFunc = f; cfgAddr = a; cfgWrData = d; cfgWr = 1'b1;
    @(negedge clk); #1;
    cfgWr = 1'b0; cfgFunc = 3'd0;
    @(negedge clk);
  endtask

  task automatic pins(input logic [3:0] v, input int n);
    @(negedge clk); #1;
    intIn = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    irqTag = "R11";
    // R1 R2 R3 R5 R6: reset contents across the address space
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); #1 cfgAddr = 8'(a);
    end
    // R4: foreign functions
    for (int f = 1; f < 8; f++) begin
      @(negedge clk); #1 cfgFunc = 3'(f); cfgAddr = 8'h41;
    end
    @(negedge clk); #1 cfgFunc = 3'd0;
    // R2 command masking
    wr(0, 8'h04, 8'hFF); wr(0, 8'h04, 8'h00); wr(0, 8'h04, 8'h08);
    // R3 status and fixed bytes
    wr(0, 8'h06, 8'hFF); wr(0, 8'h05, 8'hFF); wr(0, 8'h07, 8'h00);
    // R1 R6 discarded writes
    wr(0, 8'h00, 8'hAA); wr(0, 8'h0B, 8'h55); wr(0, 8'h0E, 8'hFF);
    wr(0, 8'h20, 8'h5A); wr(0, 8'h40, 8'hFF); wr(0, 8'h90, 8'h33);
    // R4 foreign write must not reach the routing byte
    wr(1, 8'h41, 8'h03);
    @(negedge clk); #1 cfgAddr = 8'h41;
    irqTag = "R8";
    pins(4'hF, 4);
    pins(4'h0, 2);
    irqTag = "R7";
    wr(0, 8'h41, 8'h05); wr(0, 8'h42, 8'h79); wr(0, 8'h43, 8'h0C); wr(0, 8'h44, 8'h0F);
    for (int p = 0; p < 4; p++) pins(4'(1 << p), 3);
    pins(4'h0, 2);
    irqTag = "R9";
    wr(0, 8'h43, 8'h05);
    pins(4'h1, 2); pins(4'h2, 2); pins(4'h3, 2); pins(4'h0, 2);
    irqTag = "R8";
    wr(0, 8'h42, 8'h89);
    pins(4'hF, 3);
    irqTag = "R10";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      intIn = 4'($urandom);
      cfgAddr = ($urandom % 4 == 0) ? 8'h41 + 8'($urandom % 4) : 8'($urandom);
      cfgFunc = ($urandom % 8 == 0) ? 3'($urandom) : 3'd0;
      cfgWrData = 8'($urandom);
      cfgWr = ($urandom % 5 == 0);
    end
    @(negedge clk); #1 cfgWr = 1'b0;
    @(negedge clk);
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errCnt++;
      $display("FAIL R10: watchdog expired actual=0x0 expected=0x1");
      finishRun();
    end
  end
endmodule